// File: doc/BRIEF.md
# Two-Slot Issue Hazard Controller

This block is the issue-stage control for an in-order pipeline that is scheduled at compile time and issues two instructions per cycle. Every cycle it may receive one 64-bit fetch packet. The low word holds an ALU or branch instruction for slot 0, and the high word holds a load or store for slot 1. The block decodes the register fields of both words. It then decides which slots issue, whether fetch must hold the current packet, and whether a bubble goes down the pipe.

Two hazards are handled. In the first, the memory slot reads a register that the ALU slot of the same packet writes. The pair is then split: the ALU word issues at once, and a held copy of the memory word issues alone in the next cycle. In the second, a load issued in the previous cycle writes a register that either word of the current packet reads. The whole packet then waits one cycle. Issue order never changes. When both hazards hit the same packet, the load stall comes first, and the split is decided on the retry.

The controller has two states. ST_FLOW is normal issue. ST_DEFER is the cycle that issues the held memory word. ST_FLOW goes to ST_DEFER when a valid packet has an in-packet dependency and no load-use hazard, and flush is low. ST_FLOW stays in ST_FLOW for a normal issue, a load-use stall, an empty input or a flush. ST_DEFER always returns to ST_FLOW after one cycle, and a flush also forces ST_FLOW. All outputs are combinational from the state and the inputs. The one-entry record of the last load's destination is updated on every clock.

Top module: `dual_slot_issue`

## Requirements
- R1: After reset the block is in ST_FLOW with no load recorded. With `pkt_valid` low it drives both issue valids, `fetch_stall` and `bubble` to 0, and the first packet after reset meets no load-use stall.
- R2: Slot 0 is `pkt[31:0]` and slot 1 is `pkt[63:32]`. A valid packet with no hazard issues both words in the same cycle, with `fetch_stall` = 0. An issue instruction output is all zeros whenever its valid is 0.
- R3: Source fields are bits 25:21 and 20:16. Opcode 0 reads both and writes bits 15:11. Opcodes 8 to 15 read 25:21 and write 20:16. Loads (opcodes 32 to 39) read 25:21 and write 20:16. Stores (40 to 47) and branches 4 and 5 read both fields and write nothing. Branches 6 and 7 read 25:21 only. Every other opcode reads and writes nothing.
- R4: Register 0 never causes a hazard, whether it is read or written, and an all-zero nop word never causes a stall or a split.
- R5: Suppose a valid packet in ST_FLOW, with no load-use hazard, has slot 1 reading the register that slot 0 writes. Then only slot 0 issues, `fetch_stall` = 0 (the packet is consumed), and the state becomes ST_DEFER.
- R6: In ST_DEFER, slot 0 does not issue and slot 1 issues the held memory word. `fetch_stall` = 1, and the input packet has no effect.
- R7: Suppose a load with destination d ≠ 0 issued in the previous cycle, and either word of the current packet reads d. Then neither slot issues, `fetch_stall` = 1 and `bubble` = 1. On the next cycle the same packet is judged with no load recorded.
- R8: When a load-use hazard and an in-packet dependency hit the same packet, the cycle is a load-use stall. The split happens on the following cycle.
- R9: While `flush` is 1, nothing issues and `fetch_stall` = 0. After that clock the state is ST_FLOW and no load is recorded.
- R10: In ST_FLOW with `pkt_valid` low, nothing issues and there is no stall. A load recorded before that cycle no longer stalls later packets.
- R11: `bubble` is 1 only in a load-use stall cycle, and it is never 1 in two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Pipeline flush; clears split state and load record |
| pkt_valid | input | 1 | Fetch packet present |
| pkt | input | 64 | Fetch packet: slot 0 low word, slot 1 high word |
| issue0_valid | output | 1 | Slot 0 issues this cycle |
| issue0_instr | output | 32 | Slot 0 word issued (zero when not valid) |
| issue1_valid | output | 1 | Slot 1 issues this cycle |
| issue1_instr | output | 32 | Slot 1 word issued (zero when not valid) |
| fetch_stall | output | 1 | Current packet is not consumed at this clock |
| bubble | output | 1 | Load-use stall cycle |

## Verification
The hardest condition to reach is a packet that meets both hazards at once. It requires a load in the previous packet whose destination is read by the ALU word, while that ALU word's own destination is read by the memory word. The stall must come first and the split must follow on the retry. Directed packet pairs build this case by design. A fetch-source model in the bench re-presents a packet whenever its own reference predicts a stall, so the retry arrives at the right cycle. A random phase then draws both words from only four registers and adds input gaps and flushes. This makes hazards common, and it also produces flushes that land in ST_DEFER and just after loads.

// File: rtl/dual_slot_issue_pkg.sv
package dual_slot_issue_pkg;

    localparam int REG_W    = 5;
    localparam int FIELD_W  = 21;   // bits 31:11 of a word: opcode, rs, rt, rd

    typedef struct packed {
        logic [REG_W-1:0] src_a;   // 0 when the field is not read
        logic [REG_W-1:0] src_b;
        logic [REG_W-1:0] dst;     // 0 when nothing is written
        logic             is_load;
    } reg_use_t;

    typedef enum logic {
        ST_FLOW  = 1'b0,
        ST_DEFER = 1'b1
    } issue_state_e;

endpackage

// File: rtl/dual_slot_issue_decode.sv
module dual_slot_issue_decode
    import dual_slot_issue_pkg::*;
(
    input  logic [FIELD_W-1:0] fields,   // instruction bits 31:11
    output reg_use_t           use_o
);

    logic [5:0]       opcode;
    logic [REG_W-1:0] f_rs;
    logic [REG_W-1:0] f_rt;
    logic [REG_W-1:0] f_rd;

    assign opcode = fields[20:15];
    assign f_rs   = fields[14:10];
    assign f_rt   = fields[9:5];
    assign f_rd   = fields[4:0];

    always_comb begin
        use_o = '0;
        casez (opcode)
            6'b000000: begin
                use_o.src_a = f_rs;
                use_o.src_b = f_rt;
                use_o.dst   = f_rd;
            end
            6'b00010?: begin
                use_o.src_a = f_rs;
                use_o.src_b = f_rt;
            end
            6'b00011?: begin
                use_o.src_a = f_rs;
            end
            6'b001???: begin
                use_o.src_a = f_rs;
                use_o.dst   = f_rt;
            end
            6'b100???: begin
                use_o.src_a   = f_rs;
                use_o.dst     = f_rt;
                use_o.is_load = 1'b1;
            end
            6'b101???: begin
                use_o.src_a = f_rs;
                use_o.src_b = f_rt;
            end
            default: use_o = '0;
        endcase
    end

endmodule

// File: rtl/dual_slot_issue_hazard.sv
module dual_slot_issue_hazard
    import dual_slot_issue_pkg::*;
(
    input  logic [REG_W-1:0] s0_src_a,
    input  logic [REG_W-1:0] s0_src_b,
    input  logic [REG_W-1:0] s0_dst,
    input  logic             s0_is_load,
    input  logic [REG_W-1:0] s1_src_a,
    input  logic [REG_W-1:0] s1_src_b,
    input  logic             ld_vld,
    input  logic [REG_W-1:0] ld_reg,
    output logic             load_use,
    output logic             intra
);

    function automatic logic reads_reg(input logic [REG_W-1:0] src,
                                       input logic [REG_W-1:0] tgt);
        return (tgt != '0) && (src == tgt);
    endfunction

    always_comb begin
        load_use = ld_vld && (reads_reg(s0_src_a, ld_reg) || reads_reg(s0_src_b, ld_reg) ||
                              reads_reg(s1_src_a, ld_reg) || reads_reg(s1_src_b, ld_reg));
        intra    = !s0_is_load && (reads_reg(s1_src_a, s0_dst) || reads_reg(s1_src_b, s0_dst));
    end

endmodule

// File: rtl/dual_slot_issue_fsm.sv
module dual_slot_issue_fsm
    import dual_slot_issue_pkg::*;
#(
    parameter int INSTR_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               pkt_valid,
    input  logic [INSTR_W-1:0] slot0_word,
    input  logic [INSTR_W-1:0] slot1_word,
    input  logic               load_use,
    input  logic               intra,
    input  logic [REG_W-1:0]   s1_dst,
    input  logic               s1_is_load,
    output issue_state_e       state,
    output logic [INSTR_W-1:0] held_word,
    output logic               ld_vld,
    output logic [REG_W-1:0]   ld_reg,
    output logic               issue0_valid,
    output logic [INSTR_W-1:0] issue0_instr,
    output logic               issue1_valid,
    output logic [INSTR_W-1:0] issue1_instr,
    output logic               fetch_stall,
    output logic               bubble
);

    issue_state_e state_n;
    logic         take_split;

    assign take_split = !flush && (state == ST_FLOW) && pkt_valid && !load_use && intra;

    // next-state logic
    always_comb begin
        state_n = state;
        if (flush) begin
            state_n = ST_FLOW;
        end else begin
            unique case (state)
                ST_FLOW:  state_n = take_split ? ST_DEFER : ST_FLOW;
                ST_DEFER: state_n = ST_FLOW;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_FLOW;
        else        state <= state_n;
    end

    // outputs
    always_comb begin
        issue0_valid = 1'b0;
        issue0_instr = '0;
        issue1_valid = 1'b0;
        issue1_instr = '0;
        fetch_stall  = 1'b0;
        bubble       = 1'b0;
        if (!flush) begin
            unique case (state)
                ST_FLOW: begin
                    if (pkt_valid) begin
                        if (load_use) begin
                            fetch_stall = 1'b1;
                            bubble      = 1'b1;
                        end else if (intra) begin
                            issue0_valid = 1'b1;
                            issue0_instr = slot0_word;
                        end else begin
                            issue0_valid = 1'b1;
                            issue0_instr = slot0_word;
                            issue1_valid = 1'b1;
                            issue1_instr = slot1_word;
                        end
                    end
                end
                ST_DEFER: begin
                    issue1_valid = 1'b1;
                    issue1_instr = held_word;
                    fetch_stall  = 1'b1;
                end
            endcase
        end
    end

    // held copy and load record
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_word <= '0;
            ld_vld    <= 1'b0;
            ld_reg    <= '0;
        end else begin
            if (flush)           held_word <= '0;
            else if (take_split) held_word <= slot1_word;
            ld_vld <= !flush && issue1_valid && s1_is_load && (s1_dst != '0);
            ld_reg <= s1_dst;
        end
    end

endmodule

// File: rtl/dual_slot_issue.sv
module dual_slot_issue
    import dual_slot_issue_pkg::*;
#(
    parameter int INSTR_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flush,
    input  logic                 pkt_valid,
    input  logic [2*INSTR_W-1:0] pkt,
    output logic                 issue0_valid,
    output logic [INSTR_W-1:0]   issue0_instr,
    output logic                 issue1_valid,
    output logic [INSTR_W-1:0]   issue1_instr,
    output logic                 fetch_stall,
    output logic                 bubble
);

    localparam int SLOTS    = 2;
    localparam int FIELD_LO = INSTR_W - FIELD_W;

    issue_state_e               state;
    logic [INSTR_W-1:0]         held_word;
    logic                       ld_vld;
    logic [REG_W-1:0]           ld_reg;
    logic                       load_use;
    logic                       intra;
    logic [SLOTS-1:0][INSTR_W-1:0] slot_word;
    reg_use_t                   slot_use [SLOTS];

    assign slot_word[0] = pkt[INSTR_W-1:0];
    assign slot_word[1] = (state == ST_DEFER) ? held_word : pkt[2*INSTR_W-1:INSTR_W];

    for (genvar g = 0; g < SLOTS; g++) begin : g_dec
        dual_slot_issue_decode u_dec (
            .fields (slot_word[g][INSTR_W-1:FIELD_LO]),
            .use_o  (slot_use[g])
        );
    end

    dual_slot_issue_hazard u_haz (
        .s0_src_a   (slot_use[0].src_a),
        .s0_src_b   (slot_use[0].src_b),
        .s0_dst     (slot_use[0].dst),
        .s0_is_load (slot_use[0].is_load),
        .s1_src_a   (slot_use[1].src_a),
        .s1_src_b   (slot_use[1].src_b),
        .ld_vld     (ld_vld),
        .ld_reg     (ld_reg),
        .load_use   (load_use),
        .intra      (intra)
    );

    dual_slot_issue_fsm #(.INSTR_W(INSTR_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush        (flush),
        .pkt_valid    (pkt_valid),
        .slot0_word   (slot_word[0]),
        .slot1_word   (slot_word[1]),
        .load_use     (load_use),
        .intra        (intra),
        .s1_dst       (slot_use[1].dst),
        .s1_is_load   (slot_use[1].is_load),
        .state        (state),
        .held_word    (held_word),
        .ld_vld       (ld_vld),
        .ld_reg       (ld_reg),
        .issue0_valid (issue0_valid),
        .issue0_instr (issue0_instr),
        .issue1_valid (issue1_valid),
        .issue1_instr (issue1_instr),
        .fetch_stall  (fetch_stall),
        .bubble       (bubble)
    );

endmodule

// File: rtl/dual_slot_issue_sva.sv
module dual_slot_issue_sva #(
    parameter int INSTR_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               flush,
    input logic               pkt_valid,
    input logic               issue0_valid,
    input logic [INSTR_W-1:0] issue0_instr,
    input logic               issue1_valid,
    input logic               fetch_stall,
    input logic               bubble
);

    assert_split_defers_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (issue0_valid && !issue1_valid) |=> (flush || (!issue0_valid && issue1_valid && fetch_stall)));

    assert_bubble_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bubble |-> (!issue0_valid && !issue1_valid && fetch_stall));

    assert_bubble_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bubble |=> !bubble);

    assert_flush_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (!issue0_valid && !issue1_valid && !fetch_stall && !bubble));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!pkt_valid && !fetch_stall) |-> (!issue0_valid && !issue1_valid));

    assert_zero_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !issue0_valid |-> (issue0_instr == '0));

endmodule

bind dual_slot_issue dual_slot_issue_sva #(.INSTR_W(INSTR_W)) u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush        (flush),
    .pkt_valid    (pkt_valid),
    .issue0_valid (issue0_valid),
    .issue0_instr (issue0_instr),
    .issue1_valid (issue1_valid),
    .fetch_stall  (fetch_stall),
    .bubble       (bubble)
);

// File: tb/dual_slot_issue_bench.sv
module dual_slot_issue_bench;

    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        pkt_valid = 1'b0;
    logic [63:0] pkt = '0;
    logic        issue0_valid, issue1_valid, fetch_stall, bubble;
    logic [31:0] issue0_instr, issue1_instr;

    always #(PERIOD/2) clk = ~clk;

    dual_slot_issue u_dual_slot_issue (
        .clk(clk), .rst_n(rst_n), .flush(flush), .pkt_valid(pkt_valid), .pkt(pkt),
        .issue0_valid(issue0_valid), .issue0_instr(issue0_instr),
        .issue1_valid(issue1_valid), .issue1_instr(issue1_instr),
        .fetch_stall(fetch_stall), .bubble(bubble)
    );

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // reference model state
    bit          m_defer = 0;
    bit [31:0]   m_held = 0;
    int          m_ld = 0;          // 0: nothing recorded
    bit [63:0]   q[$];
    string       phase = "R1";

    function automatic bit [31:0] enc_r(int rs, int rt, int rd);
        return {6'd0, rs[4:0], rt[4:0], rd[4:0], 5'd0, 6'h21};
    endfunction
    function automatic bit [31:0] enc_i(int op, int rs, int rt, int imm);
        return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
    endfunction

    // independent field reading by opcode number (R3)
    function automatic void ref_regs(input bit [31:0] w, output int sa, output int sb,
                                     output int dd, output bit ld);
        int op, rs, rt, rd;
        op = int'(w >> 26); rs = int'((w >> 21) & 31); rt = int'((w >> 16) & 31);
        rd = int'((w >> 11) & 31);
        sa = 0; sb = 0; dd = 0; ld = 0;
        if (op == 0)                     begin sa = rs; sb = rt; dd = rd; end
        else if (op == 4 || op == 5)     begin sa = rs; sb = rt; end
        else if (op == 6 || op == 7)     begin sa = rs; end
        else if (op >= 8 && op < 16)     begin sa = rs; dd = rt; end
        else if (op >= 32 && op < 40)    begin sa = rs; dd = rt; ld = 1; end
        else if (op >= 40 && op < 48)    begin sa = rs; sb = rt; end
    endfunction

    function automatic bit hit(int src, int tgt);
        return tgt != 0 && src == tgt;
    endfunction

    task automatic push(bit [31:0] w0, bit [31:0] w1);
        q.push_back({w1, w0});
    endtask

    task automatic check_all(string tag, bit e0v, bit [31:0] e0i, bit e1v, bit [31:0] e1i,
                             bit est, bit ebub);
        checks++;
        if (issue0_valid !== e0v || issue0_instr !== e0i || issue1_valid !== e1v ||
            issue1_instr !== e1i || fetch_stall !== est || bubble !== ebub) begin
            errors++;
            $display("FAIL %s: got v0=%0b i0=%h v1=%0b i1=%h st=%0b bub=%0b exp v0=%0b i0=%h v1=%0b i1=%h st=%0b bub=%0b",
                     tag, issue0_valid, issue0_instr, issue1_valid, issue1_instr, fetch_stall, bubble,
                     e0v, e0i, e1v, e1i, est, ebub);
        end
    endtask

    task automatic cyc(bit fl, bit gap);
        bit pv, lu, in, e0v, e1v, est, ebub;
        bit [31:0] w0, w1, e0i, e1i;
        int a0, b0, d0, a1, b1, d1, sa, sb, sd;
        bit l0, l1, sl;
        string sit;
        @(negedge clk);
        pv = !gap && q.size() > 0;
        flush = fl;
        pkt_valid = pv;
        pkt = pv ? q[0] : 64'h0;
        w0 = pkt[31:0]; w1 = pkt[63:32];
        ref_regs(w0, a0, b0, d0, l0);
        ref_regs(w1, a1, b1, d1, l1);
        lu = m_ld != 0 && (hit(a0, m_ld) || hit(b0, m_ld) || hit(a1, m_ld) || hit(b1, m_ld));
        in = !l0 && (hit(a1, d0) || hit(b1, d0));
        e0v = 0; e1v = 0; e0i = 0; e1i = 0; est = 0; ebub = 0;
        if (fl)                sit = "R9";
        else if (m_defer)      begin sit = "R6"; e1v = 1; e1i = m_held; est = 1; end
        else if (!pv)          sit = "R10";
        else if (lu)           begin sit = in ? "R8" : "R7 R11"; est = 1; ebub = 1; end
        else if (in)           begin sit = "R5"; e0v = 1; e0i = w0; end
        else                   begin sit = "R2"; e0v = 1; e0i = w0; e1v = 1; e1i = w1; end
        #(PERIOD/2 - 1);
        check_all({phase, "/", sit}, e0v, e0i, e1v, e1i, est, ebub);
        @(posedge clk);
        // model update
        ref_regs(e1i, sa, sb, sd, sl);
        m_ld = (!fl && e1v && sl) ? sd : 0;
        if (fl) begin m_defer = 0; m_held = 0; end
        else if (!m_defer && pv && !lu && in) begin m_defer = 1; m_held = w1; end
        else m_defer = 0;
        if (pv && !est) void'(q.pop_front());
    endtask

    task automatic drain();
        for (int i = 0; i < 60 && (q.size() > 0 || m_defer); i++) cyc(0, 0);
    endtask

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got hung run exp completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, idle input
        cyc(0, 0);
        // R1: first packet after reset never stalls
        phase = "R1";
        push(enc_r(5, 6, 7), enc_i(35, 8, 9, 0));
        drain();

        phase = "R2";
        push(enc_r(1, 2, 3), enc_i(35, 4, 5, 8));
        push(enc_i(8, 1, 10, 4), enc_i(43, 2, 11, 0));
        drain();

        phase = "R7";
        push(32'h0, enc_i(35, 1, 8, 0));
        push(enc_r(8, 2, 9), 32'h0);          // slot 0 reads loaded r8
        push(32'h0, enc_i(35, 1, 8, 0));
        push(32'h0, enc_i(43, 2, 8, 0));      // store data reads r8
        push(32'h0, enc_i(35, 1, 12, 0));
        push(enc_i(4, 3, 12, 0), 32'h0);      // branch reads r12
        drain();

        phase = "R5";
        push(enc_i(8, 1, 6, 4), enc_i(35, 6, 7, 0));   // addi r6 -> lw base r6
        push(enc_r(1, 2, 10), enc_i(43, 3, 10, 0));   // addu r10 -> sw data r10
        drain();

        phase = "R8";
        push(32'h0, enc_i(35, 1, 11, 0));
        push(enc_r(11, 2, 12), enc_i(35, 12, 13, 0));
        drain();

        phase = "R4";
        push(32'h0, enc_i(35, 1, 0, 0));              // load into r0
        push(enc_r(0, 0, 3), enc_i(43, 0, 0, 0));
        push(enc_i(8, 1, 0, 1), enc_i(35, 0, 4, 0));  // write r0, read r0
        push(32'h0, 32'h0);
        push(32'h0, 32'h0);
        drain();

        phase = "R3";
        push(enc_r(14, 15, 16), enc_i(35, 15, 2, 0)); // rt of R-type is a source
        push(enc_r(14, 15, 16), enc_i(35, 16, 2, 0)); // rd is the destination
        push(enc_i(4, 5, 6, 0), enc_i(43, 5, 7, 0));  // branch writes nothing
        push(32'h0, enc_i(43, 1, 9, 0));              // store writes nothing
        push(enc_r(9, 2, 3), 32'h0);
        push(enc_i(6, 17, 18, 0), enc_i(35, 18, 18, 0)); // blez reads rs only
        push(enc_i(2, 0, 19, 0), enc_i(35, 19, 20, 0));  // jump: no registers
        drain();

        phase = "R10";
        push(32'h0, enc_i(35, 1, 8, 0));
        cyc(0, 0);
        push(enc_r(8, 2, 9), 32'h0);
        cyc(0, 1);
        drain();

        phase = "R9";
        push(enc_i(8, 1, 6, 4), enc_i(35, 6, 7, 0));
        push(enc_r(1, 2, 3), 32'h0);
        cyc(0, 0);
        cyc(1, 0);            // flush in defer cycle
        drain();
        push(32'h0, enc_i(35, 1, 8, 0));
        push(enc_r(8, 2, 9), 32'h0);
        cyc(0, 0);
        cyc(1, 1);            // flush right after load
        drain();

        phase = "R11";
        for (int n = 0; n < 400; n++) begin
            bit [31:0] w0, w1;
            int k0, k1;
            k0 = int'($urandom_range(0, 3)); k1 = int'($urandom_range(0, 2));
            case (k0)
                0: w0 = enc_r(int'($urandom_range(0, 3)), int'($urandom_range(0, 3)), int'($urandom_range(0, 3)));
                1: w0 = enc_i(8, int'($urandom_range(0, 3)), int'($urandom_range(0, 3)), 1);
                2: w0 = enc_i(5, int'($urandom_range(0, 3)), int'($urandom_range(0, 3)), 2);
                default: w0 = 32'h0;
            endcase
            case (k1)
                0: w1 = enc_i(35, int'($urandom_range(0, 3)), int'($urandom_range(0, 3)), 0);
                1: w1 = enc_i(43, int'($urandom_range(0, 3)), int'($urandom_range(0, 3)), 0);
                default: w1 = 32'h0;
            endcase
            push(w0, w1);
            cyc($urandom_range(0, 39) == 0, $urandom_range(0, 7) == 0);
        end
        drain();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule